// File: doc/BRIEF.md
# Direct and Indirect Data Address Generator

This block turns the file operand of an instruction into the 9-bit address used to reach data memory. It also decides whether the access touches memory at all. In direct mode the address is made of the bank-select bits and the 7-bit file field taken from the opcode.

A file field equal to the virtual pointer register (address 00h in every bank) switches the access to indirect mode. The address then comes from an 8-bit pointer register with an indirect bank bit above it. The virtual register has no storage. When an indirect access points back at it (the pointer's low 7 bits are 00h), a read must return zero and a write must leave memory unchanged. The block flags both cases for the RAM and ALU around it.

The generator is purely combinational and adds no latency. A parameter selects whether the reserved bank bits are forced to zero. With the default, the upper direct bank bit and the indirect bank bit are ignored, so only banks 0 and 1 can be reached.

Top module: `dadr_gen`

## Requirements
- R1: When file_i is not 00h, addr_o equals {bank_sel_i[1], bank_sel_i[0], file_i}, with bank_sel_i[1] replaced by 0 when KEEP_RSV=1 (the default).
- R2: When file_i is 00h, addr_o equals {ind_bank_i, ptr_i}, with ind_bank_i replaced by 0 when KEEP_RSV=1.
- R3: With KEEP_RSV=1, changing ind_bank_i has no effect on any output, and addr_o[8] is always 0.
- R4: With KEEP_RSV=1, changing bank_sel_i[1] has no effect on any output.
- R5: rd_zero_o is 1 exactly when rd_req_i=1, file_i=00h and ptr_i[6:0]=00h. This covers pointer values 00h and 80h.
- R6: wr_suppress_o is 1 exactly when wr_req_i=1, file_i=00h and ptr_i[6:0]=00h.
- R7: A direct access (file_i not 00h), or an access without the matching request, never raises rd_zero_o or wr_suppress_o.
- R8: All outputs follow their inputs in the same cycle, without a clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| file_i | input | 7 | File address field of the opcode |
| bank_sel_i | input | 2 | Direct bank-select bits, bit 1 reserved |
| ind_bank_i | input | 1 | Indirect bank bit, reserved |
| ptr_i | input | 8 | Pointer register value |
| rd_req_i | input | 1 | Operand read request |
| wr_req_i | input | 1 | Operand write request |
| addr_o | output | 9 | Effective data-memory address |
| rd_zero_o | output | 1 | Force read data to 00h |
| wr_suppress_o | output | 1 | Block the memory write |

## Verification
The bench builds two instances. u0 uses the defaults (7-bit file field, 2 bank bits, KEEP_RSV=1). u1 uses KEEP_RSV=0, which exposes the full 9-bit address so that masking of the reserved bits can be told apart from wiring errors.

The sweeps cover all 128 file values with every bank and indirect-bank combination and every request pair, against a set of corner pointers. A second sweep runs all 256 pointer values in indirect mode. Together these reach both self-reference pointers (00h and 80h) and every neighbouring value that must not trigger.

// File: rtl/dadr_pkg.sv
package dadr_pkg;
  typedef enum logic {ACC_DIRECT = 1'b0, ACC_INDIRECT = 1'b1} acc_mode_e;
endpackage

// File: rtl/dadr_dir_path.sv
module dadr_dir_path #(
  parameter int FILE_W   = 7,
  parameter int BANK_W   = 2,
  parameter bit KEEP_RSV = 1'b1,
  localparam int ADDR_W  = FILE_W + BANK_W
) (
  input  logic [FILE_W-1:0] file_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BANK_W-1:0] bank_eff;

  generate
    if (KEEP_RSV) begin : g_mask
      localparam logic [BANK_W-1:0] LiveMask = BANK_W'(1);
      assign bank_eff = bank_i & LiveMask;
    end else begin : g_full
      assign bank_eff = bank_i;
    end
  endgenerate

  assign addr_o = {bank_eff, file_i};
endmodule

// File: rtl/dadr_ind_path.sv
module dadr_ind_path #(
  parameter int FILE_W    = 7,
  parameter int PTR_W     = 8,
  parameter bit KEEP_RSV  = 1'b1,
  parameter int VREG_ADDR = 0,
  localparam int ADDR_W   = PTR_W + 1
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              ibank_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              self_ref_o
);
  logic ibank_eff;

  generate
    if (KEEP_RSV) begin : g_mask
      assign ibank_eff = 1'b0;
    end else begin : g_full
      assign ibank_eff = ibank_i;
    end
  endgenerate

  assign addr_o     = {ibank_eff, ptr_i};
  // pointer hits the virtual register in any bank
  assign self_ref_o = (ptr_i[FILE_W-1:0] == FILE_W'(VREG_ADDR));
endmodule

// File: rtl/dadr_ctl.sv
module dadr_ctl
  import dadr_pkg::*;
#(
  parameter int FILE_W    = 7,
  parameter int ADDR_W    = 9,
  parameter int VREG_ADDR = 0
) (
  input  logic [FILE_W-1:0] file_i,
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [ADDR_W-1:0] ind_addr_i,
  input  logic              self_ref_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_zero_o,
  output logic              wr_suppress_o
);
  acc_mode_e mode;
  logic      ind_loop;

  always_comb begin
    mode = (file_i == FILE_W'(VREG_ADDR)) ? ACC_INDIRECT : ACC_DIRECT;
    ind_loop = (mode == ACC_INDIRECT) && self_ref_i;
    addr_o = (mode == ACC_INDIRECT) ? ind_addr_i : dir_addr_i;
    rd_zero_o = rd_req_i && ind_loop;
    wr_suppress_o = wr_req_i && ind_loop;
  end
endmodule

// File: rtl/dadr_gen.sv
module dadr_gen #(
  parameter int FILE_W    = 7,
  parameter int BANK_W    = 2,
  parameter bit KEEP_RSV  = 1'b1,
  parameter int VREG_ADDR = 0,
  localparam int ADDR_W   = FILE_W + BANK_W,
  localparam int PTR_W    = ADDR_W - 1
) (
  input  logic [FILE_W-1:0] file_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              ind_bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_zero_o,
  output logic              wr_suppress_o
);
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] ind_addr;
  logic              self_ref;

  dadr_dir_path #(.FILE_W(FILE_W), .BANK_W(BANK_W), .KEEP_RSV(KEEP_RSV)) u_dir (
    .file_i(file_i), .bank_i(bank_sel_i), .addr_o(dir_addr)
  );

  dadr_ind_path #(.FILE_W(FILE_W), .PTR_W(PTR_W), .KEEP_RSV(KEEP_RSV),
                  .VREG_ADDR(VREG_ADDR)) u_ind (
    .ptr_i(ptr_i), .ibank_i(ind_bank_i), .addr_o(ind_addr), .self_ref_o(self_ref)
  );

  dadr_ctl #(.FILE_W(FILE_W), .ADDR_W(ADDR_W), .VREG_ADDR(VREG_ADDR)) u_ctl (
    .file_i(file_i), .dir_addr_i(dir_addr), .ind_addr_i(ind_addr),
    .self_ref_i(self_ref), .rd_req_i(rd_req_i), .wr_req_i(wr_req_i),
    .addr_o(addr_o), .rd_zero_o(rd_zero_o), .wr_suppress_o(wr_suppress_o)
  );
endmodule

// File: rtl/dadr_gen_chk.sv
module dadr_gen_chk #(
  parameter int FILE_W    = 7,
  parameter int BANK_W    = 2,
  parameter bit KEEP_RSV  = 1'b1,
  parameter int VREG_ADDR = 0,
  localparam int ADDR_W   = FILE_W + BANK_W,
  localparam int PTR_W    = ADDR_W - 1
) (
  input logic [FILE_W-1:0] file_i,
  input logic [BANK_W-1:0] bank_sel_i,
  input logic              ind_bank_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic              rd_req_i,
  input logic              wr_req_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_zero_o,
  input logic              wr_suppress_o
);
  logic is_ind;
  assign is_ind = (file_i == FILE_W'(VREG_ADDR));

  always_comb begin
    if (!is_ind) a_r1_dir_low: assert (addr_o[FILE_W-1:0] == file_i);
    if (is_ind) a_r2_ind_low: assert (addr_o[PTR_W-1:0] == ptr_i);
    if (KEEP_RSV) a_r3_rsv_top: assert (addr_o[ADDR_W-1] == 1'b0);
    if (rd_zero_o) a_r5_rd_zero_cause: assert (rd_req_i && is_ind && addr_o[FILE_W-1:0] == FILE_W'(VREG_ADDR));
    if (wr_suppress_o) a_r6_wr_sup_cause: assert (wr_req_i && is_ind && addr_o[FILE_W-1:0] == FILE_W'(VREG_ADDR));
    if (!is_ind) a_r7_direct_clean: assert (!rd_zero_o && !wr_suppress_o);
  end
endmodule

bind dadr_gen dadr_gen_chk #(
  .FILE_W(FILE_W), .BANK_W(BANK_W), .KEEP_RSV(KEEP_RSV), .VREG_ADDR(VREG_ADDR)
) u_chk (.*);

// File: tb/sim_dadr_gen.sv
module sim_dadr_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] file;
  logic [1:0] bank;
  logic       ibank;
  logic [7:0] ptr;
  logic       rd, wr;
  logic [8:0] addr0, addr1;
  logic       rz0, ws0, rz1, ws1;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dadr_gen u0 (
    .file_i(file), .bank_sel_i(bank), .ind_bank_i(ibank), .ptr_i(ptr),
    .rd_req_i(rd), .wr_req_i(wr), .addr_o(addr0), .rd_zero_o(rz0), .wr_suppress_o(ws0)
  );

  dadr_gen #(.KEEP_RSV(1'b0)) u1 (
    .file_i(file), .bank_sel_i(bank), .ind_bank_i(ibank), .ptr_i(ptr),
    .rd_req_i(rd), .wr_req_i(wr), .addr_o(addr1), .rd_zero_o(rz1), .wr_suppress_o(ws1)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s file=%h bank=%b ib=%b ptr=%h rd=%b wr=%b act=%h exp=%h",
               req, file, bank, ibank, ptr, rd, wr, act, exp);
    end
  endtask

  task automatic check_all();
    logic       ind;
    logic       loop;
    logic [8:0] e0, e1;
    ind  = (file == 7'h00);
    loop = ind && (ptr[6:0] == 7'h00);
    e0 = ind ? {1'b0, ptr} : {1'b0, bank[0], file};
    e1 = ind ? {ibank, ptr} : {bank, file};
    if (ind) begin
      chk("R2/R3", addr0, e0);
      chk("R2", addr1, e1);
    end else begin
      chk("R1/R4", addr0, e0);
      chk("R1", addr1, e1);
    end
    chk("R5", {8'd0, rz0}, {8'd0, rd && loop});
    chk("R6", {8'd0, ws0}, {8'd0, wr && loop});
    chk("R7", {7'd0, rz1, ws1}, {7'd0, rd && loop, wr && loop});
  endtask

  logic [7:0] corner_ptrs [8] = '{8'h00, 8'h80, 8'h01, 8'h81, 8'h7F, 8'hFF, 8'h40, 8'h5A};

  initial begin
    file = '0; bank = '0; ibank = 1'b0; ptr = '0; rd = 1'b0; wr = 1'b0;
    #(CLK_PERIOD/2 + 1);
    // reset state of inputs: indirect through pointer 00h, no requests
    chk("R2 reset", addr0, 9'h000);
    chk("R7 reset", {7'd0, rz0, ws0}, 9'd0);
    rst_ni = 1'b1;

    // R8: same-cycle response, no clock edge between change and sample
    @(negedge clk);
    file = 7'h00; ptr = 8'h80; rd = 1'b1; wr = 1'b1;
    #1;
    chk("R8 rd", {8'd0, rz0}, 9'd1);
    chk("R8 wr", {8'd0, ws0}, 9'd1);
    file = 7'h15; bank = 2'b01;
    #1;
    chk("R8 addr", addr0, 9'h095);

    for (int f = 0; f < 128; f++)
      for (int b = 0; b < 4; b++)
        for (int ib = 0; ib < 2; ib++)
          for (int p = 0; p < 8; p++)
            for (int q = 0; q < 4; q++) begin
              file = 7'(f); bank = 2'(b); ibank = 1'(ib);
              ptr = corner_ptrs[p]; {rd, wr} = 2'(q);
              #1;
              check_all();
            end

    file = 7'h00;
    for (int p = 0; p < 256; p++)
      for (int ib = 0; ib < 2; ib++)
        for (int q = 0; q < 4; q++) begin
          ptr = 8'(p); ibank = 1'(ib); {rd, wr} = 2'(q);
          #1;
          check_all();
        end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule